// File: doc/BRIEF.md
# Received Data Word Match Detector

This block sits beside the receive path of a serial bus controller and watches the stream of received data words. Each word arrives with a valid strobe. A separate pulse marks the start of a transfer, and it covers both a plain START and a repeated START. Whenever the selected match condition holds, the block sets a sticky match flag. Software clears the flag by writing a one to the clear input.

Two pattern registers, `pat_a` and `pat_b`, are compared with the words. A 3-bit mode selects one of the conditions below:

- a first-word comparison or an any-word comparison against either pattern;
- a two-word sequence, in which a word equal to `pat_a` is followed directly by a word equal to `pat_b`;
- a masked comparison, in which `pat_b` acts as a bit mask.

The only state the block keeps is the position of the next word within the transfer and whether the previous word equalled `pat_a`.

Top module: `rx_word_match`

## Requirements
- R1: After reset `match_flag` is 0.
- R2: Modes 3'b000 and 3'b001 never set the flag, whatever words arrive.
- R3: Mode 3'b010 sets the flag when the first word of a transfer equals `pat_a` or equals `pat_b`.
- R4: Mode 3'b011 sets the flag when any word equals `pat_a` or equals `pat_b`.
- R5: Mode 3'b100 sets the flag only when the first word equals `pat_a` and the second word equals `pat_b`.
- R6: Mode 3'b101 sets the flag when a word equals `pat_b` and the word just before it in the same transfer equals `pat_a`.
- R7: Mode 3'b110 sets the flag when (first word & `pat_b`) equals (`pat_a` & `pat_b`).
- R8: Mode 3'b111 applies the masked comparison of R7 to every word.
- R9: A `xfer_start` pulse makes the next valid word the first word of a transfer and forgets the previous-word state. If the pulse coincides with `word_vld`, that same word counts as the first word.
- R10: The flag stays set until a cycle with `flag_clr` high, and it reads 0 after that cycle if no match occurred in it.
- R11: When a match and `flag_clr` occur in the same cycle, the flag is set.
- R12: The flag changes one clock after the strobed word. Cycles without `word_vld` change neither the flag nor the word position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_vld | input | 1 | Received word strobe |
| word_data | input | W | Received data word |
| xfer_start | input | 1 | Start or repeated start: the next word is the first of a transfer |
| mode | input | 3 | Match condition select |
| pat_a | input | W | First pattern register |
| pat_b | input | W | Second pattern register, also the mask in masked modes |
| flag_clr | input | 1 | Write-1 clear of the match flag |
| match_flag | output | 1 | Sticky match flag |

## Verification
Every result is due exactly one clock after the cycle that causes it. This covers a set from a strobed word, a clear, and the reset value. The bench drives a cycle's inputs on a falling edge and compares the flag on the next falling edge, after the single register stage has captured the result. It also samples the flag just after driving, before the rising edge, to confirm that no result appears early. Between words the bench inserts idle cycles whose data equals `pat_a`, and it checks the flag at each of them. A stray update on an idle cycle, or a shift in word position, would therefore show up at the very next sample.

// File: rtl/rx_word_match.sv
module rx_word_match #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         word_vld,
  input  logic [W-1:0] word_data,
  input  logic         xfer_start,
  input  logic [2:0]   mode,
  input  logic [W-1:0] pat_a,
  input  logic [W-1:0] pat_b,
  input  logic         flag_clr,
  output logic         match_flag
);
  localparam logic [2:0] M_FIRST_OR = 3'b010;
  localparam logic [2:0] M_ANY_OR   = 3'b011;
  localparam logic [2:0] M_FIRST_SQ = 3'b100;
  localparam logic [2:0] M_ANY_SQ   = 3'b101;
  localparam logic [2:0] M_FIRST_MK = 3'b110;
  localparam logic [2:0] M_ANY_MK   = 3'b111;

  // position: 0 = first word next, 1 = second, 2 = later
  logic [1:0] pos_q, pos_cur;
  logic       prev_a_q, prev_a_cur;
  logic       eq_a, eq_b, mask_eq, is_first, is_second, hit;

  assign pos_cur    = xfer_start ? 2'd0 : pos_q;
  assign prev_a_cur = xfer_start ? 1'b0 : prev_a_q;
  assign is_first   = (pos_cur == 2'd0);
  assign is_second  = (pos_cur == 2'd1);
  assign eq_a       = (word_data == pat_a);
  assign eq_b       = (word_data == pat_b);
  assign mask_eq    = ((word_data & pat_b) == (pat_a & pat_b));

  always_comb begin
    case (mode)
      M_FIRST_OR: hit = is_first & (eq_a | eq_b);
      M_ANY_OR:   hit = eq_a | eq_b;
      M_FIRST_SQ: hit = is_second & prev_a_cur & eq_b;
      M_ANY_SQ:   hit = prev_a_cur & eq_b;
      M_FIRST_MK: hit = is_first & mask_eq;
      M_ANY_MK:   hit = mask_eq;
      default:    hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q    <= 2'd0;
      prev_a_q <= 1'b0;
    end else if (word_vld) begin
      pos_q    <= (pos_cur == 2'd2) ? 2'd2 : pos_cur + 2'd1;
      prev_a_q <= eq_a;
    end else if (xfer_start) begin
      pos_q    <= 2'd0;
      prev_a_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      match_flag <= 1'b0;
    else if (word_vld && hit)
      match_flag <= 1'b1;
    else if (flag_clr)
      match_flag <= 1'b0;
  end

  // R12
  rise_needs_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_flag) |-> $past(word_vld));

  // R2
  disabled_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode[2:1] == 2'b00 && !match_flag) |-> !match_flag);

  // R10
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(match_flag && !flag_clr) |-> match_flag);

  // R10
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flag_clr && !word_vld) |-> !match_flag);

  // R11
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(word_vld && mode == M_ANY_OR && word_data == pat_a) |-> match_flag);
endmodule

// File: tb/rx_word_match_tb.sv
module rx_word_match_tb;
  localparam int W = 8;
  localparam logic [W-1:0] PA = 8'hA5;
  localparam logic [W-1:0] PB = 8'hF0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic word_vld = 1'b0, xfer_start = 1'b0, flag_clr = 1'b0;
  logic [W-1:0] word_data = '0;
  logic [2:0] mode = 3'b000;
  logic match_flag;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  rx_word_match #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word_data(word_data),
    .xfer_start(xfer_start), .mode(mode), .pat_a(PA), .pat_b(PB),
    .flag_clr(flag_clr), .match_flag(match_flag));

  task automatic chk(input logic exp, input string req);
    checks++;
    if (match_flag !== exp) begin
      errors++;
      $display("FAIL %s: match_flag=%b expected=%b (mode=%b)", req, match_flag, exp, mode);
    end
  endtask

  // one cycle: drive at falling edge, check at the next falling edge
  task automatic cyc(input logic v, input logic [W-1:0] d, input logic st, input logic clr);
    word_vld = v; word_data = d; xfer_start = st; flag_clr = clr;
    @(negedge clk);
    word_vld = 1'b0; xfer_start = 1'b0; flag_clr = 1'b0;
  endtask

  function automatic logic exp_hit(input logic [2:0] m, input int idx,
                                   input logic [W-1:0] prv, input logic [W-1:0] w);
    logic masked;
    masked = ((w & PB) == (PA & PB));
    case (m)
      3'b010: return idx == 0 && (w == PA || w == PB);
      3'b011: return w == PA || w == PB;
      3'b100: return idx == 1 && prv == PA && w == PB;
      3'b101: return idx >= 1 && prv == PA && w == PB;
      3'b110: return idx == 0 && masked;
      3'b111: return masked;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] m);
    case (m)
      3'b010: return "R3";
      3'b011: return "R4";
      3'b100: return "R5";
      3'b101: return "R6";
      3'b110: return "R7";
      3'b111: return "R8";
      default: return "R2";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] alpha [4];
    logic exp;
    alpha[0] = PA; alpha[1] = PB; alpha[2] = 8'hA3; alpha[3] = 8'h35;
    word_data = 8'hA5; word_vld = 1'b1;
    repeat (3) @(negedge clk);
    word_vld = 1'b0;
    rst_n = 1'b1;
    chk(1'b0, "R1");

    // exhaustive sweep: 8 modes x 64 three-word transfers
    for (int m = 0; m < 8; m++) begin
      mode = 3'(m);
      for (int s = 0; s < 64; s++) begin
        logic [W-1:0] w [3];
        logic [W-1:0] prv;
        w[0] = alpha[s % 4]; w[1] = alpha[(s / 4) % 4]; w[2] = alpha[s / 16];
        cyc(1'b0, PA, 1'b0, 1'b1);
        chk(1'b0, "R10");
        exp = 1'b0;
        prv = '0;
        if (s % 2 == 0) cyc(1'b0, PB, 1'b1, 1'b0);  // R9 start pulse on its own
        for (int i = 0; i < 3; i++) begin
          // R9: odd sequences start with the pulse coinciding with the first word
          word_vld = 1'b1; word_data = w[i]; xfer_start = (s % 2 == 1) && i == 0;
          #1 chk(exp, "R12");
          @(negedge clk);
          word_vld = 1'b0; xfer_start = 1'b0;
          exp = exp | exp_hit(3'(m), i, prv, w[i]);
          prv = w[i];
          chk(exp, req_of(3'(m)));
          cyc(1'b0, PA, 1'b0, 1'b0);  // R12 unstrobed word ignored
          chk(exp, "R12");
        end
        cyc(1'b0, '0, 1'b0, 1'b0);
        chk(exp, "R10");
      end
    end

    // R11: set and clear in the same cycle
    mode = 3'b011;
    cyc(1'b0, '0, 1'b0, 1'b1);
    chk(1'b0, "R10");
    cyc(1'b1, PA, 1'b1, 1'b1);
    chk(1'b1, "R11");

    // R9: start pulse forgets a pending pat_a word
    mode = 3'b101;
    cyc(1'b0, '0, 1'b0, 1'b1);
    cyc(1'b1, PA, 1'b1, 1'b0);
    cyc(1'b0, '0, 1'b1, 1'b0);
    cyc(1'b1, PB, 1'b0, 1'b0);
    chk(1'b0, "R9");
    cyc(1'b1, PA, 1'b0, 1'b0);
    cyc(1'b1, PB, 1'b0, 1'b0);
    chk(1'b1, "R6");

    // R9: restart makes the next word first again in mode 3'b010
    mode = 3'b010;
    cyc(1'b0, '0, 1'b0, 1'b1);
    cyc(1'b1, 8'h35, 1'b1, 1'b0);
    cyc(1'b1, PA, 1'b0, 1'b0);
    chk(1'b0, "R3");
    cyc(1'b0, '0, 1'b1, 1'b0);
    cyc(1'b1, PB, 1'b0, 1'b0);
    chk(1'b1, "R9");

    // R5: a restarted transfer needs pat_a as its new first word
    mode = 3'b100;
    cyc(1'b0, '0, 1'b0, 1'b1);
    cyc(1'b1, 8'h35, 1'b1, 1'b0);
    cyc(1'b1, PA, 1'b1, 1'b0);
    cyc(1'b1, PB, 1'b0, 1'b0);
    chk(1'b1, "R5");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule